// File: doc/BRIEF.md
# SPI Dual-Channel Gain Programmer

This block programs a two-channel programmable pre-amplifier over a write-mostly SPI link. A host presents two gain codes, one for each channel, and pulses a start request. The block packs the two codes into a single command word and shifts it out most significant bit first. It drives the active-low chip select and a divided serial clock that idles low. While the word goes out, it collects the bits the amplifier returns. Those bits hold the setting the amplifier carried before this frame, and the block keeps them in a readback register.

All serial timing comes from parameters given in the system clock rate and in nanoseconds, and is converted to whole cycles at elaboration time. Each SCK phase lasts the larger of two values: half the period at the maximum serial clock rate, and the minimum phase width. The spacing from chip select falling to the first clock edge, from the last clock edge to chip select rising, and the quiet gap before a new frame may begin are each rounded up to whole cycles. Busy covers the whole frame and the trailing gap. A one-cycle done pulse marks the end of a frame.

Top module: `gain_prog_spi`

## Requirements
- R1: While reset is held and after it is released, cs_n_o is 1, sck_o, mosi_o, busy_o and done_o are 0, and echo_o is 0.
- R2: The frame carries {gain_b_i, gain_a_i} as sampled on the accepted start edge. The wire order is gain_b_i[3] first, down to gain_b_i[0], then gain_a_i[3] down to gain_a_i[0]. mosi_o is 0 whenever chip select is high.
- R3: mosi_o changes only in the cycle in which sck_o falls or in which chip select falls. It is constant in every cycle in which sck_o is high.
- R4: sck_o is 0 whenever cs_n_o is 1. After cs_n_o falls, sck_o first rises SETUP_CYC cycles later, where SETUP_CYC = ceil(CS_SETUP_NS*SYS_CLK_MHZ/1000).
- R5: sck_o makes exactly 8 high phases and 7 low phases between them, each lasting HALF_CYC cycles. HALF_CYC is the larger of ceil(SYS_CLK_MHZ/(2*SCK_MAX_MHZ)) and ceil(MIN_PHASE_NS*SYS_CLK_MHZ/1000).
- R6: After the eighth falling edge of sck_o, cs_n_o stays low for HOLD_CYC = ceil(CS_HOLD_NS*SYS_CLK_MHZ/1000) cycles and then rises.
- R7: miso_i is sampled at each rising edge of sck_o, at the system clock edge that raises it. The first sample becomes echo_o[7] and the eighth becomes echo_o[0].
- R8: done_o is a one-cycle pulse in the first cycle in which cs_n_o is high again. echo_o takes its new value in that same cycle and changes at no other time.
- R9: busy_o is high from the cycle after an accepted start until GAP_CYC = ceil(GAP_NS*SYS_CLK_MHZ/1000) cycles after cs_n_o rises. A start_i that is high while busy_o is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Request a frame; accepted only while not busy |
| gain_a_i | input | GAIN_W | Channel A gain code, sent second |
| gain_b_i | input | GAIN_W | Channel B gain code, sent first |
| busy_o | output | 1 | Frame or inter-frame gap in progress |
| done_o | output | 1 | One-cycle end-of-frame pulse |
| echo_o | output | 2*GAIN_W | Previous amplifier setting read back during the last frame |
| cs_n_o | output | 1 | Active-low chip select to the amplifier |
| sck_o | output | 1 | Serial clock, idles low |
| mosi_o | output | 1 | Serial command data |
| miso_i | input | 1 | Serial echo data from the amplifier |

## Verification
The bench builds the block with a 200 MHz system clock, a 25 MHz serial limit, a 30 ns phase floor, 35 ns setup, 20 ns hold and a 40 ns gap. These give phase, setup, hold and gap lengths of 6, 7, 4 and 8 cycles. Because the phase floor outweighs the rate limit, the choice of the larger term in the phase length is exercised. Because every spacing differs, a constant placed in the wrong state shows up as a wrong edge position. The slave echo is preloaded with distinct patterns, so the capture order and the update of the readback can be seen. Starts that arrive mid-frame and starts held high across frames exercise the busy window and back-to-back framing.

// File: rtl/gp_pkg.sv
// Package: shared state type and elaboration-time helpers for the gain programmer.
// Assumes all timing parameters are positive integers.
package gp_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_HIGH,
        ST_LOW,
        ST_HOLD,
        ST_GAP
    } gp_state_t;

    // Integer ceiling division, used to turn nanoseconds into cycles.
    function automatic int unsigned cdiv(input int unsigned num, input int unsigned den);
        return (num + den - 1) / den;
    endfunction

    // Larger of two values, never below one cycle.
    function automatic int unsigned max_cyc(input int unsigned x, input int unsigned y);
        int unsigned m;
        m = (x > y) ? x : y;
        return (m < 1) ? 1 : m;
    endfunction

endpackage

// File: rtl/gp_pace.sv
// Module: gp_pace
// A reloadable down-counter that times each phase of a frame.
// A load of value N makes zero_o go high N cycles later; the owner loads
// (phase length - 1) on entry, so the phase lasts exactly its length.
module gp_pace #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             zero_o
);

    logic [CNT_W-1:0] cnt_q;

    // Reload on request, otherwise count down and rest at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/gp_shift.sv
// Module: gp_shift
// Holds the outgoing command word and the incoming echo bits.
// Assumes load and shift are never requested in the same cycle.
// Shifting fills with zero, so the line rests low once all bits are sent.
module gp_shift #(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [WORD_W-1:0] word_i,
    input  logic              shift_i,
    input  logic              capture_i,
    input  logic              miso_i,
    output logic              mosi_o,
    output logic [WORD_W-1:0] rx_o
);

    logic [WORD_W-1:0] tx_q;
    logic [WORD_W-1:0] rx_q;

    // Transmit register: parallel load, then MSB-first shift.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_q <= '0;
        end else if (load_i) begin
            tx_q <= word_i;
        end else if (shift_i) begin
            tx_q <= {tx_q[WORD_W-2:0], 1'b0};
        end
    end

    // Receive register: cleared at frame start, shifted on each sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_q <= '0;
        end else if (load_i) begin
            rx_q <= '0;
        end else if (capture_i) begin
            rx_q <= {rx_q[WORD_W-2:0], miso_i};
        end
    end

    assign mosi_o = tx_q[WORD_W-1];
    assign rx_o   = rx_q;

    assert_load_shift_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(load_i && shift_i));

endmodule

// File: rtl/gp_seq.sv
// Module: gp_seq
// Frame sequencer: walks setup, 8 high/low clock phases, hold and gap.
// It drives chip select, serial clock and busy as registered outputs, and
// issues the strobes for the shifter and the pacing counter.
// Assumes each phase length is at least one cycle.
module gp_seq
    import gp_pkg::*;
#(
    parameter int WORD_W    = 8,
    parameter int CNT_W     = 4,
    parameter int SETUP_CYC = 6,
    parameter int HALF_CYC  = 10,
    parameter int HOLD_CYC  = 6,
    parameter int GAP_CYC   = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             pace_zero_i,
    output logic             pace_load_o,
    output logic [CNT_W-1:0] pace_val_o,
    output logic             load_o,
    output logic             shift_o,
    output logic             capture_o,
    output logic             commit_o,
    output logic             cs_n_o,
    output logic             sck_o,
    output logic             busy_o
);

    localparam int BIT_W = $clog2(WORD_W);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(WORD_W - 1);

    gp_state_t        state_q, state_d;
    logic [BIT_W-1:0] bit_q;
    logic             cs_n_q, sck_q, busy_q;

    // Next-state and strobe decode for the current phase.
    always_comb begin
        state_d     = state_q;
        pace_load_o = 1'b0;
        pace_val_o  = '0;
        load_o      = 1'b0;
        shift_o     = 1'b0;
        capture_o   = 1'b0;
        commit_o    = 1'b0;
        unique case (state_q)
            ST_IDLE: if (start_i) begin
                load_o      = 1'b1;
                pace_load_o = 1'b1;
                pace_val_o  = CNT_W'(SETUP_CYC - 1);
                state_d     = ST_SETUP;
            end
            ST_SETUP: if (pace_zero_i) begin
                capture_o   = 1'b1;
                pace_load_o = 1'b1;
                pace_val_o  = CNT_W'(HALF_CYC - 1);
                state_d     = ST_HIGH;
            end
            ST_HIGH: if (pace_zero_i) begin
                shift_o     = 1'b1;
                pace_load_o = 1'b1;
                if (bit_q == LAST_BIT) begin
                    pace_val_o = CNT_W'(HOLD_CYC - 1);
                    state_d    = ST_HOLD;
                end else begin
                    pace_val_o = CNT_W'(HALF_CYC - 1);
                    state_d    = ST_LOW;
                end
            end
            ST_LOW: if (pace_zero_i) begin
                capture_o   = 1'b1;
                pace_load_o = 1'b1;
                pace_val_o  = CNT_W'(HALF_CYC - 1);
                state_d     = ST_HIGH;
            end
            ST_HOLD: if (pace_zero_i) begin
                commit_o    = 1'b1;
                pace_load_o = 1'b1;
                pace_val_o  = CNT_W'(GAP_CYC - 1);
                state_d     = ST_GAP;
            end
            ST_GAP: if (pace_zero_i) begin
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register and the registered line drivers derived from next state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cs_n_q  <= 1'b1;
            sck_q   <= 1'b0;
            busy_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            cs_n_q  <= (state_d == ST_IDLE) || (state_d == ST_GAP);
            sck_q   <= (state_d == ST_HIGH);
            busy_q  <= (state_d != ST_IDLE);
        end
    end

    // Bit counter: cleared on acceptance, advanced on every falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_q <= '0;
        end else if (load_o) begin
            bit_q <= '0;
        end else if (shift_o) begin
            bit_q <= bit_q + 1'b1;
        end
    end

    assign cs_n_o = cs_n_q;
    assign sck_o  = sck_q;
    assign busy_o = busy_q;

    assert_sck_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_o |-> !sck_o);
    assert_busy_cover_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> cs_n_o);
    assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |-> !load_o);

endmodule

// File: rtl/gain_prog_spi.sv
// Module: gain_prog_spi (top)
// Programs a two-channel pre-amplifier over SPI and reads back its previous
// setting. All timing is derived from the clock rate and nanosecond limits.
// Assumes miso_i is synchronous enough to sample directly (slow serial link).
module gain_prog_spi
    import gp_pkg::*;
#(
    parameter int GAIN_W       = 4,
    parameter int SYS_CLK_MHZ  = 200,
    parameter int SCK_MAX_MHZ  = 10,
    parameter int MIN_PHASE_NS = 50,
    parameter int CS_SETUP_NS  = 30,
    parameter int CS_HOLD_NS   = 30,
    parameter int GAP_NS       = 50
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [GAIN_W-1:0]   gain_a_i,
    input  logic [GAIN_W-1:0]   gain_b_i,
    output logic                busy_o,
    output logic                done_o,
    output logic [2*GAIN_W-1:0] echo_o,
    output logic                cs_n_o,
    output logic                sck_o,
    output logic                mosi_o,
    input  logic                miso_i
);

    localparam int WORD_W    = 2 * GAIN_W;
    localparam int HALF_CYC  = int'(max_cyc(cdiv(SYS_CLK_MHZ, 2 * SCK_MAX_MHZ),
                                            cdiv(MIN_PHASE_NS * SYS_CLK_MHZ, 1000)));
    localparam int SETUP_CYC = int'(max_cyc(cdiv(CS_SETUP_NS * SYS_CLK_MHZ, 1000), 1));
    localparam int HOLD_CYC  = int'(max_cyc(cdiv(CS_HOLD_NS * SYS_CLK_MHZ, 1000), 1));
    localparam int GAP_CYC   = int'(max_cyc(cdiv(GAP_NS * SYS_CLK_MHZ, 1000), 1));
    localparam int MAX_CYC   = int'(max_cyc(max_cyc(HALF_CYC, SETUP_CYC),
                                            max_cyc(HOLD_CYC, GAP_CYC)));
    localparam int CNT_W     = $clog2(MAX_CYC + 1);

    logic             pace_load, pace_zero;
    logic [CNT_W-1:0] pace_val;
    logic             load, shift, capture, commit;
    logic [WORD_W-1:0] rx;
    logic [WORD_W-1:0] echo_q;
    logic              done_q;

    gp_pace #(.CNT_W(CNT_W)) u_pace (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (pace_load),
        .load_val_i (pace_val),
        .zero_o     (pace_zero)
    );

    gp_seq #(
        .WORD_W    (WORD_W),
        .CNT_W     (CNT_W),
        .SETUP_CYC (SETUP_CYC),
        .HALF_CYC  (HALF_CYC),
        .HOLD_CYC  (HOLD_CYC),
        .GAP_CYC   (GAP_CYC)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .pace_zero_i (pace_zero),
        .pace_load_o (pace_load),
        .pace_val_o  (pace_val),
        .load_o      (load),
        .shift_o     (shift),
        .capture_o   (capture),
        .commit_o    (commit),
        .cs_n_o      (cs_n_o),
        .sck_o       (sck_o),
        .busy_o      (busy_o)
    );

    gp_shift #(.WORD_W(WORD_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (load),
        .word_i    ({gain_b_i, gain_a_i}),
        .shift_i   (shift),
        .capture_i (capture),
        .miso_i    (miso_i),
        .mosi_o    (mosi_o),
        .rx_o      (rx)
    );

    // Readback register and done pulse, both set as chip select rises.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            echo_q <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= commit;
            if (commit) begin
                echo_q <= rx;
            end
        end
    end

    assign echo_o = echo_q;
    assign done_o = done_q;

    assert_mosi_steady_R3: assert property (@(posedge clk) disable iff (!rst_n)
        sck_o |-> $stable(mosi_o));
    assert_mosi_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_o |-> !mosi_o);
    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    assert_echo_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(echo_o));
    assert_done_at_cs_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (cs_n_o && !$past(cs_n_o)));

endmodule

// File: tb/gain_prog_spi_bench.sv
// Bench: behavioural slave and elapsed-cycle reference model, compared each cycle.
module gain_prog_spi_bench;

    localparam int SYS = 200;
    localparam int H = 6;   // max(ceil(200/50), ceil(30*200/1000))
    localparam int S = 7;   // ceil(35*200/1000)
    localparam int D = 4;   // ceil(20*200/1000)
    localparam int G = 8;   // ceil(40*200/1000)
    localparam int F = S + 15 * H + D;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [3:0] ga = '0, gb = '0;
    logic busy, done, cs_n, sck, mosi, miso;
    logic [7:0] echo;

    int checks = 0;
    int fails = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;

    gain_prog_spi #(
        .GAIN_W(4), .SYS_CLK_MHZ(SYS), .SCK_MAX_MHZ(25), .MIN_PHASE_NS(30),
        .CS_SETUP_NS(35), .CS_HOLD_NS(20), .GAP_NS(40)
    ) u_gain_prog_spi (
        .clk(clk), .rst_n(rst_n), .start_i(start), .gain_a_i(ga), .gain_b_i(gb),
        .busy_o(busy), .done_o(done), .echo_o(echo), .cs_n_o(cs_n), .sck_o(sck),
        .mosi_o(mosi), .miso_i(miso)
    );

    task automatic chk(input string tag, input logic [31:0] a, input logic [31:0] e);
        checks++;
        if (a !== e) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, a, e);
        end
    endtask

    // Behavioural slave: echoes previous contents, takes new word on select rise.
    logic [7:0] slave_reg = 8'hA5;
    logic [7:0] slave_rx = '0;
    int s_idx = 8;
    logic p_sck = 1'b0, p_cs = 1'b1;
    always @(negedge clk) begin
        if (p_cs && !cs_n) begin s_idx = 0; slave_rx = '0; end
        if (!p_sck && sck) slave_rx = {slave_rx[6:0], mosi};
        if (p_sck && !sck) s_idx++;
        if (!p_cs && cs_n) slave_reg = slave_rx;
        p_sck = sck; p_cs = cs_n;
    end
    assign miso = (s_idx < 8) ? slave_reg[7 - s_idx] : 1'b0;

    // Reference model: elapsed cycles since the accepted start.
    bit act = 0;
    int k = 0;
    logic [7:0] word = '0, snap = '0, exp_echo = '0;
    always @(posedge clk) begin
        if (!rst_n) begin
            act = 0; k = 0; exp_echo = '0;
        end else if (act) begin
            if (k == F + G) act = 0;
            else begin
                k++;
                if (k == F + 1) exp_echo = snap;
            end
        end else if (start) begin
            act = 1; k = 1; word = {gb, ga}; snap = slave_reg;
        end
    end

    // Per-cycle comparison against the model, away from the active edge.
    logic pm_sck = 1'b0, pm_mosi = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            int n;
            logic e_cs_n, e_sck, e_mosi;
            e_cs_n = !(act && k <= F);
            e_sck  = act && k > S && k <= S + 15 * H && (((k - S - 1) / H) % 2 == 0);
            n = (!act || k <= S) ? 0 : (((k - S - 1) / H) + 1) / 2;
            e_mosi = (act && n < 8) ? word[7 - n] : 1'b0;
            chk("R6 cs_n", 32'(cs_n), 32'(e_cs_n));
            chk("R5 sck", 32'(sck), 32'(e_sck));
            chk("R2 mosi", 32'(mosi), 32'(e_mosi));
            chk("R9 busy", 32'(busy), 32'(act));
            chk("R8 done", 32'(done), 32'(act && k == F + 1));
            chk("R7 echo", 32'(echo), 32'(exp_echo));
            if (cs_n) chk("R4 sck idle", 32'(sck), 32'd0);
            if (sck && pm_sck) chk("R3 mosi steady", 32'(mosi), 32'(pm_mosi));
        end
        pm_sck = sck; pm_mosi = mosi;
    end

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    task automatic frame(input logic [3:0] a, input logic [3:0] b);
        wait_idle();
        ga = a; gb = b; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    // Watchdog.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 200000) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1: state held during reset.
        chk("R1 cs_n", 32'(cs_n), 32'd1);
        chk("R1 sck", 32'(sck), 32'd0);
        chk("R1 mosi", 32'(mosi), 32'd0);
        chk("R1 busy", 32'(busy), 32'd0);
        chk("R1 done", 32'(done), 32'd0);
        chk("R1 echo", 32'(echo), 32'd0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        frame(4'h3, 4'h7);                 // R2: distinct nibbles
        repeat (20) @(negedge clk);        // R9: starts mid-frame ignored
        ga = 4'hC; gb = 4'hD; start = 1'b1;
        repeat (3) @(negedge clk);
        start = 1'b0; ga = 4'h0; gb = 4'h0;
        frame(4'hF, 4'h0);
        wait_idle();
        slave_reg = 8'h81;                 // R7: edge bits only
        frame(4'h5, 4'hA);
        wait_idle();
        slave_reg = 8'h3C;
        ga = 4'h6; gb = 4'h4; start = 1'b1; // R9: held start, back-to-back frames
        repeat (2 * (F + G) + 5) @(negedge clk);
        start = 1'b0;
        wait_idle();
        repeat (10) @(negedge clk);
        chk("R8 echo after idle", 32'(echo), 32'(exp_echo));
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule